// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder with Optional Output Register

This block adds two N-bit unsigned operands and a carry-in and produces an N-bit sum and a carry-out. No carry travels bit by bit. Every bit first forms a generate/propagate pair. A prefix network of identical combine nodes then resolves all carries at once. The network is a divide-and-conquer tree of minimum depth: at each level, every position in the upper half of an aligned block takes the running result of the last position in the lower half. The number of readers of a single node therefore doubles at each level and reaches half the width at the last one.

The carry-in enters the network as one extra position below bit 0. It has generate equal to the carry-in and propagate equal to zero. Every resolved group generate is then a finished carry, and no fix-up stage follows the tree. The top of the tree gives the carry-out. A parameter selects whether sum and carry-out leave through a register stage or come straight from the combinational path. The register stage has a synchronous active-low reset.

Top module: `lf_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^N for every operand pair, including random operands.
- R2: `cout` equals bit N of the (N+1)-bit result of `a` + `b` + `cin`.
- R3: With `a` all ones, `b` zero and `cin` = 1, `sum` is zero and `cout` is 1.
- R4: With `a` all ones, `b` = 1 and `cin` = 0, `sum` is zero and `cout` is 1, so a carry made at bit 0 reaches the carry-out.
- R5: With `REG_OUT` = 1 (the default), `sum` and `cout` take the result of the inputs present at a rising edge of `clk` and hold it until the next edge, whatever the inputs do in between.
- R6: With `REG_OUT` = 1, a rising edge with `rst_n` = 0 sets `sum` to zero and `cout` to 0, whatever the operands are.
- R7: A carry chain of any length k from 1 to N resolves correctly: for `a` holding ones in bits 0..k-1, `b` zero and `cin` = 1, the {`cout`,`sum`} value is 2^k.
- R8: The zero pattern (all inputs zero) gives zero. The complementary alternating patterns (`a` bits set at odd positions, `b` bits set at even positions) give all ones with `cin` = 0, and zero with carry-out 1 with `cin` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous active-low reset of the output register stage |
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
A wrong node or a wrong partner index in the prefix tree leaves one carry wrong. That carry shows as a flipped `sum` bit just above the faulty group, or as a wrong `cout` for the top group. With the register stage this appears at the edge after the operands are presented. Walking carry chains of every length put each tree level on the critical path in turn. The all-ones, alternating and random operands load the nodes with high fan-out. A stuck or missing reset, or a register that follows its input between edges, shows at the first sample after the reset edge or between two edges.

// File: rtl/lfa_pkg.sv
// Package: shared types and helpers for the parallel-prefix adder.
// Assumes: nothing beyond IEEE 1800-2017.
package lfa_pkg;

    // One generate/propagate pair carried through the prefix tree.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge an upper group with the adjacent lower group.
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (lo.g & hi.p);
        r.p = lo.p & hi.p;
        return r;
    endfunction

    // Number of tree levels needed to span a given width.
    function automatic int prefix_levels(int width);
        return (width <= 1) ? 0 : $clog2(width);
    endfunction

endpackage

// File: rtl/lfa_gp_node.sv
// Module: one combine node of the prefix tree.
// Assumes: 'hi' covers bit positions directly above those of 'lo'.
module lfa_gp_node
    import lfa_pkg::*;
(
    input  gp_t hi,
    input  gp_t lo,
    output gp_t res
);
    // Purpose: merge the two adjacent groups.
    assign res = gp_merge(hi, lo);
endmodule

// File: rtl/lfa_pregen.sv
// Module: per-bit generate/propagate forming, with the carry-in placed
// as an extra lowest position (generate = cin, propagate = 0).
// Assumes: output position i+1 belongs to operand bit i.
module lfa_pregen #(
    parameter int N = 32
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N:0]   g_ext,
    output logic [N:0]   p_ext
);
    // Purpose: seed the lowest position from the carry-in.
    assign g_ext[0] = cin;
    assign p_ext[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: bit-level generate and propagate.
        assign g_ext[i+1] = a[i] & b[i];
        assign p_ext[i+1] = a[i] ^ b[i];
    end
endmodule

// File: rtl/lfa_prefix_net.sv
// Module: minimum-depth prefix tree over W positions. At level k, every
// position with index bit k set merges with the last position of the
// preceding 2^k-aligned block; other positions pass straight through.
// Assumes: W >= 1; fan-out of a node reaches 2^(levels-1).
module lfa_prefix_net
    import lfa_pkg::*;
#(
    parameter int W = 33
) (
    input  logic [W-1:0] g_in,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] g_out,
    output logic [W-1:0] p_out
);
    localparam int L = prefix_levels(W);

    wire gp_t stage [L+1][W];

    for (genvar i = 0; i < W; i++) begin : g_io
        // Purpose: load level 0 and expose the last level.
        assign stage[0][i] = {g_in[i], p_in[i]};
        assign g_out[i]    = stage[L][i].g;
        assign p_out[i]    = stage[L][i].p;
    end

    for (genvar k = 0; k < L; k++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_pos
            if (((i >> k) & 1) == 1) begin : g_merge
                localparam int J = ((i >> k) << k) - 1;
                // Purpose: merge with the end of the lower half-block.
                lfa_gp_node u_node (
                    .hi  (stage[k][i]),
                    .lo  (stage[k][J]),
                    .res (stage[k+1][i])
                );
            end else begin : g_pass
                // Purpose: carry the finished group to the next level.
                assign stage[k+1][i] = stage[k][i];
            end
        end
    end
endmodule

// File: rtl/lf_adder.sv
// Module: N-bit parallel-prefix adder with optional output register.
// Assumes: REG_OUT = 1 gives one cycle of latency with a synchronous
// active-low reset; REG_OUT = 0 gives a purely combinational path.
module lf_adder #(
    parameter int N       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int W = N + 1;

    logic [W-1:0] g_ext;
    logic [W-1:0] p_ext;
    logic [W-1:0] grp_g;
    logic [W-1:0] grp_p;
    logic [N:0]   carry_w;
    logic [N-1:0] sum_c;
    logic         cout_c;
    logic         unused_grp_p;

    lfa_pregen #(.N(N)) u_pregen (
        .a     (a),
        .b     (b),
        .cin   (cin),
        .g_ext (g_ext),
        .p_ext (p_ext)
    );

    lfa_prefix_net #(.W(W)) u_tree (
        .g_in  (g_ext),
        .p_in  (p_ext),
        .g_out (grp_g),
        .p_out (grp_p)
    );

    // Purpose: group generates from the carry-in upward are the carries.
    assign carry_w      = grp_g;
    assign unused_grp_p = ^grp_p;

    // Purpose: sum bits and carry-out from the resolved carries.
    assign sum_c  = p_ext[N:1] ^ carry_w[N-1:0];
    assign cout_c = carry_w[N];

    if (REG_OUT) begin : g_reg
        logic [N-1:0] sum_q;
        logic         cout_q;
        // Purpose: output register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_q  <= '0;
                cout_q <= 1'b0;
            end else begin
                sum_q  <= sum_c;
                cout_q <= cout_c;
            end
        end
        assign sum  = sum_q;
        assign cout = cout_q;
    end else begin : g_comb
        logic unused_clk;
        // Purpose: direct combinational outputs; clock and reset idle.
        assign unused_clk = clk ^ rst_n;
        assign sum  = sum_c;
        assign cout = cout_c;
    end
endmodule

// File: rtl/lf_adder_chk.sv
// Module: assertion checker bound to lf_adder. Compares the outputs with
// a behavioural sum and checks each resolved carry against the
// bit-serial carry recurrence.
// Assumes: rst_n is held low from time zero until the first edges.
module lf_adder_chk #(
    parameter int N       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         cin,
    input logic [N-1:0] sum,
    input logic         cout,
    input logic [N:0]   carry
);
    logic [N:0] model_w;

    // Purpose: behavioural reference sum.
    assign model_w = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

    if (REG_OUT) begin : g_reg
        assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> sum == $past(model_w[N-1:0]));
        assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> cout == $past(model_w[N]));
        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(a) && $stable(b) && $stable(cin) && $past(rst_n))
            |=> $stable(sum) && $stable(cout));
        assert_reset_R6: assert property (@(posedge clk)
            !rst_n |=> (sum == '0) && !cout);
    end else begin : g_comb
        assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            sum == model_w[N-1:0]);
        assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cout == model_w[N]);
    end

    assert_cin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry[0] == cin);

    for (genvar i = 0; i < N; i++) begin : g_chain
        assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
            carry[i+1] == ((a[i] & b[i]) | ((a[i] ^ b[i]) & carry[i])));
    end
endmodule

bind lf_adder lf_adder_chk #(.N(N), .REG_OUT(REG_OUT)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .carry (carry_w)
);

// File: tb/lf_adder_tb_top.sv
// Bench: directed tests for lf_adder with the register stage enabled.
module lf_adder_tb_top;
    localparam int N          = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic         cin = 1'b0;
    logic [N-1:0] sum;
    logic         cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    lf_adder #(.N(N), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [N:0] expect_of(logic [N-1:0] x, logic [N-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
    endfunction

    task automatic check(string tag, logic [N:0] got, logic [N:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, check after the next rising edge.
    task automatic apply(string tag, logic [N-1:0] x, logic [N-1:0] y, logic c);
        @(negedge clk);
        a = x; b = y; cin = c;
        @(negedge clk);
        check(tag, {cout, sum}, expect_of(x, y, c));
    endtask

    task automatic t_reset_start();
        a = '1; b = '1; cin = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 reset at start", {cout, sum}, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_zero_alt();
        apply("R8 zero", '0, '0, 1'b0);
        apply("R8 alternating cin0", {(N/2){2'b10}}, {(N/2){2'b01}}, 1'b0);
        apply("R8 alternating cin1", {(N/2){2'b10}}, {(N/2){2'b01}}, 1'b1);
    endtask

    task automatic t_edges();
        apply("R3 all ones plus cin", '1, '0, 1'b1);
        check("R3 constant", {cout, sum}, {1'b1, {N{1'b0}}});
        apply("R4 all ones plus one", '1, {{(N-1){1'b0}}, 1'b1}, 1'b0);
        check("R4 constant", {cout, sum}, {1'b1, {N{1'b0}}});
        apply("R1 all ones both", '1, '1, 1'b1);
    endtask

    task automatic t_walk();
        for (int k = 1; k <= N; k++) begin
            logic [N-1:0] ones;
            logic [N:0]   pow;
            ones = '1 >> (N - k);
            pow  = '0;
            pow[k] = 1'b1;
            apply("R7 carry chain", ones, '0, 1'b1);
            check("R7 power of two", {cout, sum}, pow);
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 64; i++) begin
            logic [N-1:0] x;
            logic [N-1:0] y;
            logic         c;
            logic [N:0]   e;
            x = $urandom; y = $urandom; c = 1'($urandom);
            e = expect_of(x, y, c);
            @(negedge clk);
            a = x; b = y; cin = c;
            @(negedge clk);
            check("R1 random sum", {1'b0, sum}, {1'b0, e[N-1:0]});
            check("R2 random carry", {{N{1'b0}}, cout}, {{N{1'b0}}, e[N]});
        end
    endtask

    task automatic t_hold();
        logic [N-1:0] x2;
        apply("R5 first value", 32'h1234_5678, 32'h0F0F_0F0F, 1'b0);
        x2 = 32'h8000_0001;
        a = x2; b = x2; cin = 1'b1;
        #2;
        check("R5 hold between edges", {cout, sum},
              expect_of(32'h1234_5678, 32'h0F0F_0F0F, 1'b0));
        @(negedge clk);
        check("R5 update at edge", {cout, sum}, expect_of(x2, x2, 1'b1));
    endtask

    task automatic t_reset_mid();
        apply("R1 before reset", 32'hDEAD_BEEF, 32'hFFFF_0000, 1'b1);
        @(negedge clk);
        rst_n = 1'b0; a = '1; b = '1; cin = 1'b1;
        @(negedge clk);
        check("R6 reset mid run", {cout, sum}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after release", {cout, sum}, expect_of('1, '1, 1'b1));
    endtask

    initial begin
        t_reset_start();
        t_zero_alt();
        t_edges();
        t_walk();
        t_random();
        t_hold();
        t_reset_mid();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule